// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from an external three-wire serial EEPROM of the Microwire kind. A host issues a read by writing one 32-bit command word that carries a start flag and a word address. The block requests the serial pins, waits for a grant, and sends a read frame. It then shifts the returned word in and posts it in the upper half of the same register, with a done flag that the host polls.

A second entry point walks the whole 64-word image in address order. It keeps every word in local storage and sums the words modulo 2^16. The image counts as valid only when that sum equals 0xBABA. The first three stored words also form a 48-bit station address, which is presented directly on a port.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, `cmd_rdata` reads 0, `ee_cs`, `ee_sk`, `ee_di` and `arb_req` are low, and `load_done` and `csum_err` are low.
- R2: A write with `cmd_wdata[0]`=1 while nothing is busy starts a read. On the next cycle `cmd_rdata[0]` (busy) is 1, `cmd_rdata[1]` (done) is 0, and `cmd_rdata[15:2]` echoes `cmd_wdata[15:2]`. The EEPROM word fetched is the one at `cmd_wdata[7:2]`.
- R3: A command write while a host read is in flight changes nothing. A write with `cmd_wdata[0]`=0 changes nothing at any time.
- R4: A read frame keeps `ee_cs` high for 25 `ee_sk` pulses. On the first nine pulses `ee_di` carries 1, 1, 0 and then the six address bits MSB first. On the remaining sixteen pulses `ee_do` is taken MSB first. `ee_di` never changes while `ee_sk` is high.
- R5: When the frame ends, the fetched word appears in `cmd_rdata[31:16]`, done becomes 1 and busy returns to 0.
- R6: Each `ee_sk` high and low phase lasts `cfg_div`+1 system clocks, so the serial period is 2*(`cfg_div`+1) clocks.
- R7: Between two frames, `ee_cs` stays low for at least one full serial period.
- R8: `arb_req` is high while any read is pending or running. `ee_cs` stays low until `arb_gnt` is high.
- R9: A pulse on `load_go` while idle reads words 0 to 63 in order and stores them. `load_busy` is high throughout, and `img_word` shows the stored word selected by `img_idx`.
- R10: At the end of a load, `load_done` rises. `csum_err` is 0 if the 16-bit wrapping sum of the 64 words is 0xBABA, and 1 otherwise.
- R11: `station_addr` is {word2, word1, word0} of the stored image, so byte n of the address sits at bits 8n+7:8n, low byte of each word first.
- R12: `pin_view` shows `ee_sk` on bit 0, `ee_cs` on bit 1, `ee_di` on bit 2, `ee_do` on bit 3, `arb_req` on bit 6 and `arb_gnt` on bit 7, with the other bits 0.
- R13: While a load runs, host start writes are ignored and `cmd_rdata[0]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Serial half-period minus one, in system clocks |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command write data: start bit 0, address 15:2 |
| cmd_rdata | output | 32 | Register view: busy 0, done 1, address 15:2, data 31:16 |
| load_go | input | 1 | Pulse to begin an image load |
| load_busy | output | 1 | Image load in progress |
| load_done | output | 1 | Image load finished |
| csum_err | output | 1 | Image sum differs from 0xBABA |
| img_idx | input | 6 | Stored image word select |
| img_word | output | 16 | Stored image word |
| station_addr | output | 48 | Station address from words 0 to 2 |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| arb_req | output | 1 | Request for the serial pins |
| arb_gnt | input | 1 | Grant of the serial pins |
| pin_view | output | 8 | Packed pin and handshake view |

## Verification
The bench drives a behavioural EEPROM that decodes each frame, so a reordered header, an LSB-first address or a shift that is off by one gives the wrong word or the wrong decoded address. Back-to-back load reads check the chip-select gap, because a design that drops the idle period between frames would merge two frames into one. A second start written mid-read and a write with the start bit clear both target the busy and ignore rules; a design that accepts either would return a different word or a changed address field. Loads are run with a sum that matches and with one that is off by one, which separates a correct compare from an off-by-one or stuck error flag. The grant is withheld at first to catch a design that drives chip select before it owns the pins.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 6;
    localparam int IMG_WORDS    = 1 << ADDR_W;
    localparam int HDR_W        = 3;
    localparam logic [HDR_W-1:0] CMD_HDR = 3'b110;
    localparam int CMD_BITS     = HDR_W + ADDR_W;
    localparam int FRAME_BITS   = CMD_BITS + DATA_W;
    localparam int BIT_W        = $clog2(FRAME_BITS);
    localparam logic [DATA_W-1:0] IMG_SIG = 16'hBABA;
    localparam int STATION_WORDS = 3;
    localparam int STATION_W    = STATION_WORDS * DATA_W;

    // register layout: the host decodes these positions
    localparam int F_START      = 0;
    localparam int F_ADDR_LO    = 2;
    localparam int ADDR_FIELD_W = 14;

    // pin view layout
    localparam int PIN_SK  = 0;
    localparam int PIN_CS  = 1;
    localparam int PIN_DI  = 2;
    localparam int PIN_DO  = 3;
    localparam int PIN_REQ = 6;
    localparam int PIN_GNT = 7;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_SETUP,
        SER_SHIFT,
        SER_GAP
    } ser_state_e;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_HOST,
        OWN_LOAD
    } owner_e;

    typedef struct packed {
        logic [DATA_W-1:0]       data;
        logic [ADDR_FIELD_W-1:0] addr;
        logic                    done;
        logic                    busy;
    } rd_view_t;

    typedef struct packed {
        logic sk;
        logic cs;
        logic di;
        logic dout;
        logic req;
        logic gnt;
    } pins_t;

    function automatic logic [7:0] pack_pins(input pins_t p);
        logic [7:0] v;
        v = '0;
        v[PIN_SK]  = p.sk;
        v[PIN_CS]  = p.cs;
        v[PIN_DI]  = p.di;
        v[PIN_DO]  = p.dout;
        v[PIN_REQ] = p.req;
        v[PIN_GNT] = p.gnt;
        return v;
    endfunction
endpackage

// File: rtl/eerd_tick_gen.sv
module eerd_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == div);
endmodule

// File: rtl/eerd_serial.sv
module eerd_serial
    import eerd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ee_sk,
    output logic              ee_cs,
    output logic              ee_di
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    ser_state_e            st_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [BIT_W-1:0]      bit_q;
    logic                  phase_q;
    logic                  gap_q;
    logic                  sk_q;
    logic                  cs_q;
    logic                  done_q;
    logic                  tick;

    eerd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (st_q != SER_IDLE),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SER_IDLE;
            sh_q    <= '0;
            bit_q   <= '0;
            phase_q <= 1'b0;
            gap_q   <= 1'b0;
            sk_q    <= 1'b0;
            cs_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                SER_IDLE: begin
                    if (start) begin
                        st_q    <= SER_SETUP;
                        cs_q    <= 1'b1;
                        sh_q    <= {CMD_HDR, addr, {DATA_W{1'b0}}};
                        bit_q   <= '0;
                        phase_q <= 1'b0;
                    end
                end
                SER_SETUP: begin
                    if (tick) begin
                        st_q <= SER_SHIFT;
                    end
                end
                SER_SHIFT: begin
                    if (tick) begin
                        if (!phase_q) begin
                            sk_q    <= 1'b1;
                            phase_q <= 1'b1;
                        end else begin
                            sk_q    <= 1'b0;
                            phase_q <= 1'b0;
                            sh_q    <= {sh_q[FRAME_BITS-2:0], ee_do};
                            if (bit_q == BIT_LAST) begin
                                st_q  <= SER_GAP;
                                cs_q  <= 1'b0;
                                gap_q <= 1'b0;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                SER_GAP: begin
                    if (tick) begin
                        if (gap_q) begin
                            st_q   <= SER_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            gap_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= SER_IDLE;
            endcase
        end
    end

    assign busy  = (st_q != SER_IDLE);
    assign done  = done_q;
    assign data  = sh_q[DATA_W-1:0];
    assign ee_sk = sk_q;
    assign ee_cs = cs_q;
    assign ee_di = (st_q == SER_SHIFT) && sh_q[FRAME_BITS-1];

    // R4: clock pulses only inside a chip-select window
    a_r4_sk_inside_cs: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R4: data-in held steady across the high phase
    a_r4_di_held_high: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R7: chip select never pulses low for a single cycle
    a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_cs) |=> !ee_cs);

    // R6: serial clock edges happen only on divider ticks
    a_r6_sk_on_tick: assert property (@(posedge clk) disable iff (rst)
        (ee_sk != $past(ee_sk)) |-> $past(tick));
endmodule

// File: rtl/eerd_loader.sv
module eerd_loader
    import eerd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 begin_i,
    input  logic                 launched,
    input  logic                 word_ok,
    input  logic [DATA_W-1:0]    word,
    input  logic [ADDR_W-1:0]    rd_idx,
    output logic                 active,
    output logic                 want,
    output logic [ADDR_W-1:0]    idx,
    output logic                 load_done,
    output logic                 csum_err,
    output logic [DATA_W-1:0]    rd_word,
    output logic [STATION_W-1:0] station
);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    logic [DATA_W-1:0] img_q [IMG_WORDS];
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] sum_n;
    logic [ADDR_W-1:0] idx_q;
    logic              active_q;
    logic              want_q;
    logic              done_q;
    logic              err_q;

    assign sum_n = sum_q + word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IMG_WORDS; i++) begin
                img_q[i] <= '0;
            end
            sum_q    <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
            want_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (begin_i) begin
                active_q <= 1'b1;
                want_q   <= 1'b1;
                idx_q    <= '0;
                sum_q    <= '0;
                done_q   <= 1'b0;
                err_q    <= 1'b0;
            end
            if (launched) begin
                want_q <= 1'b0;
            end
            if (word_ok && active_q) begin
                img_q[idx_q] <= word;
                sum_q        <= sum_n;
                if (idx_q == IDX_LAST) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    err_q    <= (sum_n != IMG_SIG);
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    want_q <= 1'b1;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < STATION_WORDS; g++) begin : g_station
            assign station[g*DATA_W +: DATA_W] = img_q[g];
        end
    endgenerate

    assign active    = active_q;
    assign want      = want_q;
    assign idx       = idx_q;
    assign load_done = done_q;
    assign csum_err  = err_q;
    assign rd_word   = img_q[rd_idx];

    // R10: error flag only together with a finished load
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        csum_err |-> load_done);

    // R9: index advances by exactly one per stored word
    a_r9_idx_step: assert property (@(posedge clk) disable iff (rst)
        (word_ok && active_q && (idx_q != IDX_LAST)) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import eerd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic                  cmd_we,
    input  logic [31:0]           cmd_wdata,
    output logic [31:0]           cmd_rdata,
    input  logic                  load_go,
    output logic                  load_busy,
    output logic                  load_done,
    output logic                  csum_err,
    input  logic [ADDR_W-1:0]     img_idx,
    output logic [DATA_W-1:0]     img_word,
    output logic [STATION_W-1:0]  station_addr,
    output logic                  ee_sk,
    output logic                  ee_cs,
    output logic                  ee_di,
    input  logic                  ee_do,
    output logic                  arb_req,
    input  logic                  arb_gnt,
    output logic [7:0]            pin_view
);
    logic                    host_busy_q;
    logic                    host_want_q;
    logic                    host_done_q;
    logic [ADDR_FIELD_W-1:0] host_addr_q;
    logic [DATA_W-1:0]       host_data_q;

    logic                    ser_busy;
    logic                    ser_done;
    logic [DATA_W-1:0]       ser_data;
    logic [ADDR_W-1:0]       ser_addr;
    logic                    eng_start;

    logic                    ld_active;
    logic                    ld_want;
    logic [ADDR_W-1:0]       ld_idx;

    logic                    start_ok;
    logic                    go_ok;
    owner_e                  owner;
    rd_view_t                view;
    pins_t                   pins;
    logic                    wdata_unused;

    assign wdata_unused = ^{cmd_wdata[31:F_ADDR_LO+ADDR_FIELD_W], cmd_wdata[1]};

    assign owner = ld_active   ? OWN_LOAD :
                   host_busy_q ? OWN_HOST : OWN_NONE;

    assign start_ok  = cmd_we && cmd_wdata[F_START] && (owner == OWN_NONE);
    assign go_ok     = load_go && (owner == OWN_NONE) && !start_ok;
    assign eng_start = !ser_busy && arb_gnt && (host_want_q || ld_want);
    assign ser_addr  = (owner == OWN_LOAD) ? ld_idx : host_addr_q[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            host_busy_q <= 1'b0;
            host_want_q <= 1'b0;
            host_done_q <= 1'b0;
            host_addr_q <= '0;
            host_data_q <= '0;
        end else begin
            if (start_ok) begin
                host_busy_q <= 1'b1;
                host_want_q <= 1'b1;
                host_done_q <= 1'b0;
                host_addr_q <= cmd_wdata[F_ADDR_LO +: ADDR_FIELD_W];
            end
            if (eng_start && (owner == OWN_HOST)) begin
                host_want_q <= 1'b0;
            end
            if (ser_done && (owner == OWN_HOST)) begin
                host_busy_q <= 1'b0;
                host_done_q <= 1'b1;
                host_data_q <= ser_data;
            end
        end
    end

    eerd_serial #(.DIV_W(DIV_W)) u_serial (
        .clk   (clk),
        .rst   (rst),
        .div   (cfg_div),
        .start (eng_start),
        .addr  (ser_addr),
        .ee_do (ee_do),
        .busy  (ser_busy),
        .done  (ser_done),
        .data  (ser_data),
        .ee_sk (ee_sk),
        .ee_cs (ee_cs),
        .ee_di (ee_di)
    );

    eerd_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .begin_i   (go_ok),
        .launched  (eng_start && (owner == OWN_LOAD)),
        .word_ok   (ser_done && (owner == OWN_LOAD)),
        .word      (ser_data),
        .rd_idx    (img_idx),
        .active    (ld_active),
        .want      (ld_want),
        .idx       (ld_idx),
        .load_done (load_done),
        .csum_err  (csum_err),
        .rd_word   (img_word),
        .station   (station_addr)
    );

    always_comb begin
        view.data = host_data_q;
        view.addr = host_addr_q;
        view.done = host_done_q;
        view.busy = host_busy_q;
    end
    assign cmd_rdata = view;

    assign arb_req   = host_busy_q || ld_active;
    assign load_busy = ld_active;

    always_comb begin
        pins.sk   = ee_sk;
        pins.cs   = ee_cs;
        pins.di   = ee_di;
        pins.dout = ee_do;
        pins.req  = arb_req;
        pins.gnt  = arb_gnt;
    end
    assign pin_view = pack_pins(pins);

    // R3: a write during a host read leaves the address field alone
    a_r3_busy_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (host_busy_q && cmd_we) |=> $stable(cmd_rdata[15:2]));

    // R2: an accepted start clears done and raises busy
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (cmd_rdata[0] && !cmd_rdata[1]));

    // R8: chip select only while the pins are requested
    a_r8_cs_needs_req: assert property (@(posedge clk) disable iff (rst)
        ee_cs |-> arb_req);

    // R13: host read and image load never overlap
    a_r13_one_owner: assert property (@(posedge clk) disable iff (rst)
        !(host_busy_q && ld_active));
endmodule

// File: tb/eeprom_word_reader_tb.sv
`timescale 1ns/100ps
module eeprom_word_reader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_div = 8'd0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        load_go = 1'b0;
    logic        load_busy, load_done, csum_err;
    logic [5:0]  img_idx = '0;
    logic [15:0] img_word;
    logic [47:0] station_addr;
    logic        ee_sk, ee_cs, ee_di;
    logic        ee_do = 1'b0;
    logic        arb_req;
    logic        arb_gnt = 1'b1;
    logic [7:0]  pin_view;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eeprom_word_reader #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .load_go(load_go), .load_busy(load_busy), .load_done(load_done),
        .csum_err(csum_err), .img_idx(img_idx), .img_word(img_word),
        .station_addr(station_addr), .ee_sk(ee_sk), .ee_cs(ee_cs),
        .ee_di(ee_di), .ee_do(ee_do), .arb_req(arb_req),
        .arb_gnt(arb_gnt), .pin_view(pin_view)
    );

    // behavioural serial EEPROM
    logic [15:0] mem [64];
    int          rise_n = 0;
    logic [8:0]  cmd_sh = '0;
    bit          hdr_ok = 0;
    logic [5:0]  seen_addr = '0;
    realtime     t_rise1 = 0;
    int          per_cyc = 0;
    realtime     t_fall = 0;
    bit          have_fall = 0;
    int          min_gap = 1000000;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            rise_n = 0;
        end else begin
            rise_n = rise_n + 1;
            if (rise_n == 1) t_rise1 = $realtime;
            if (rise_n == 2) per_cyc = int'(($realtime - t_rise1) / 5.0);
            if (rise_n <= 9) cmd_sh = {cmd_sh[7:0], ee_di};
            if (rise_n == 9) begin
                hdr_ok    = (cmd_sh[8:6] == 3'b110);
                seen_addr = cmd_sh[5:0];
            end
            if (rise_n >= 10 && rise_n <= 25)
                ee_do <= mem[seen_addr][25 - rise_n];
        end
    end

    always @(negedge ee_cs) begin
        t_fall = $realtime;
        have_fall = 1;
    end

    always @(posedge ee_cs) begin
        if (have_fall) begin
            int g;
            g = int'(($realtime - t_fall) / 5.0);
            if (g < min_gap) min_gap = g;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            summary();
        end
    end

    function automatic logic [15:0] image_sum(input int upto);
        logic [15:0] s = '0;
        for (int i = 0; i < upto; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!cmd_rdata[1] && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic host_read(input logic [13:0] a, input logic [7:0] dv);
        cfg_div = dv;
        write_cmd({16'h0, a, 2'b01});
        chk(cmd_rdata[0] && !cmd_rdata[1], "R2 busy set done cleared", cmd_rdata[1:0], 2'b01);
        chk(cmd_rdata[15:2] == a, "R2 address echo", cmd_rdata[15:2], a);
        wait_done();
        chk(cmd_rdata[31:16] == mem[a[5:0]], "R5 data word", cmd_rdata[31:16], mem[a[5:0]]);
        chk(cmd_rdata[1:0] == 2'b10, "R5 done and idle", cmd_rdata[1:0], 2'b10);
        chk(hdr_ok && seen_addr == a[5:0], "R4 frame header and address", {hdr_ok, seen_addr}, {1'b1, a[5:0]});
        chk(per_cyc == 2 * (int'(dv) + 1), "R6 serial period", per_cyc, 2 * (int'(dv) + 1));
    endtask

    task automatic run_load(input bit make_bad);
        int n = 0;
        logic [15:0] s;
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        s = image_sum(63);
        mem[63] = 16'hBABA - s + (make_bad ? 16'd1 : 16'd0);
        cfg_div = 8'd0;
        min_gap = 1000000;
        @(negedge clk);
        load_go = 1'b1;
        @(negedge clk);
        load_go = 1'b0;
        chk(load_busy && !load_done, "R9 load busy", {load_busy, load_done}, 2'b10);
        write_cmd(32'h0000_0011);
        chk(cmd_rdata[0] == 1'b0, "R13 host start ignored during load", cmd_rdata[0], 0);
        while (!load_done && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(load_done && !load_busy, "R10 load finished", {load_done, load_busy}, 2'b10);
        chk(csum_err == make_bad, "R10 checksum flag", csum_err, make_bad);
        chk(station_addr == {mem[2], mem[1], mem[0]}, "R11 station address", station_addr, {mem[2], mem[1], mem[0]});
        chk(min_gap >= 2, "R7 chip select gap", min_gap, 2);
        foreach (img_idx_list[k]) begin
            img_idx = img_idx_list[k];
            @(negedge clk);
            chk(img_word == mem[img_idx_list[k]], "R9 stored image word", img_word, mem[img_idx_list[k]]);
        end
    endtask

    logic [5:0] img_idx_list [4] = '{6'd0, 6'd17, 6'd42, 6'd63};

    initial begin
        logic [31:0] saved;
        void'($urandom(32'd20250611));
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_rdata == 32'h0, "R1 register after reset", cmd_rdata, 0);
        chk({ee_cs, ee_sk, ee_di, arb_req, load_done, csum_err} == 6'b0, "R1 pins after reset",
            {ee_cs, ee_sk, ee_di, arb_req, load_done, csum_err}, 0);

        // directed edge addresses, then random ones
        host_read(14'd0, 8'd0);
        host_read(14'd63, 8'd1);
        host_read(14'h3FFF, 8'd2);
        for (int i = 0; i < 8; i++) begin
            host_read(14'($urandom), 8'($urandom % 4));
        end

        // R3 start while busy is ignored
        cfg_div = 8'd3;
        write_cmd({16'h0, 14'd9, 2'b01});
        repeat (5) @(negedge clk);
        write_cmd({16'h0, 14'd40, 2'b01});
        chk(cmd_rdata[15:2] == 14'd9, "R3 address kept while busy", cmd_rdata[15:2], 9);
        wait_done();
        chk(cmd_rdata[31:16] == mem[9], "R3 first read wins", cmd_rdata[31:16], mem[9]);
        // R3 write without start bit
        saved = cmd_rdata;
        write_cmd({16'hFFFF, 14'd22, 2'b10});
        repeat (40) @(negedge clk);
        chk(cmd_rdata == saved && !ee_cs, "R3 write without start ignored", cmd_rdata, saved);

        // R8 and R12 grant handshake
        arb_gnt = 1'b0;
        cfg_div = 8'd1;
        write_cmd({16'h0, 14'd5, 2'b01});
        repeat (30) @(negedge clk);
        chk(!ee_cs && arb_req && cmd_rdata[0], "R8 no chip select without grant", {ee_cs, arb_req, cmd_rdata[0]}, 3'b011);
        chk(pin_view == 8'b0100_0000, "R12 pin view request only", pin_view, 8'h40);
        arb_gnt = 1'b1;
        while (!ee_sk) @(negedge clk);
        chk(pin_view[7:6] == 2'b11 && pin_view[1:0] == 2'b11 && pin_view[5:4] == 2'b00,
            "R12 pin view during frame", pin_view, 8'hC3);
        wait_done();
        chk(cmd_rdata[31:16] == mem[5], "R8 read after grant", cmd_rdata[31:16], mem[5]);
        chk(!arb_req, "R8 request dropped when idle", arb_req, 0);

        // R9 R10 R11 loader, good and bad images
        run_load(1'b0);
        run_load(1'b1);

        // host read still works after loads, using the last image
        host_read(14'd33, 8'd0);

        summary();
    end
endmodule